// File: doc/BRIEF.md
# Video Source Selector with Test Patterns

This block decides what pixel value goes out in every active pixel slot of a video raster. A timing generator upstream supplies data-enable, a start-of-frame pulse and a marker on the last active pixel of the frame. A 2-bit selector picks one of four pixel sources: nothing (output held at zero), a live pixel stream taken through a valid/ready handshake, an incrementing test ramp, or a programmable 24-bit constant colour. The chosen pixel leaves one clock later, in step with a registered copy of data-enable.

In live mode the block asks the stream for a word only when a pixel slot is active. It also keeps two sticky error flags. Underflow records that a pixel slot came with no word available. Overflow records that the stream ran ahead of the raster. Software clears a flag by writing 1 to its bit. A separate request bit is carried through to a registered output, so the stage downstream can skip chroma subsampling and send test patterns through unchanged.

A small frame state machine tracks where the raster is. WAIT is the state after reset, before any frame has begun. ACTIVE lasts from a start-of-frame to the last active pixel. BLANK lasts from the last active pixel to the next start-of-frame. The transitions are: WAIT to ACTIVE on start-of-frame, ACTIVE to BLANK on the last active pixel, BLANK to ACTIVE on start-of-frame, and ACTIVE to ACTIVE on a repeated start-of-frame. A start-of-frame that falls on the last active pixel goes straight to BLANK.

Top module: `vid_src_sel`

## Requirements
- R1: While reset is asserted, px_de, px_out, flags and ss_bypass are all zero.
- R2: px_de equals de_in delayed by one clock, and px_out is zero whenever px_de is low.
- R3: With src_sel = 0 (disabled), px_out stays zero and s_ready stays low.
- R4: With src_sel = 3 (constant), each active pixel produces const_px, sampled in the same cycle as de_in.
- R5: With src_sel = 2 (ramp), the ramp value is 0 on the first active pixel at or after sof_in. It then rises by one on each later active pixel, whatever the selected source. The active pixel that coincides with sof_in carries 0.
- R6: With src_sel = 1 (live), s_ready equals de_in, and s_ready is low in every other mode. An active pixel with s_valid high produces s_data[23:0].
- R7: In live mode, an active pixel with s_valid low sets flags[0] (underflow), and that pixel comes out as zero.
- R8: In live mode, a word accepted with s_eof high on a pixel where last_in is low sets flags[1] (overflow).
- R9: In live mode, s_valid high while the frame machine is in BLANK, with no sof_in in that cycle, sets flags[1] (overflow).
- R10: Flags are sticky. A 1 in flag_clr[0] clears underflow and a 1 in flag_clr[1] clears overflow, one cycle later. If a set and a clear hit the same flag in the same cycle, the set wins.
- R11: ss_bypass equals bypass_req delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source: 0 off, 1 live, 2 ramp, 3 constant |
| const_px | input | 24 | Constant RGB value |
| bypass_req | input | 1 | Request to skip chroma subsampling |
| de_in | input | 1 | Active-pixel slot from the timing generator |
| sof_in | input | 1 | Start-of-frame pulse |
| last_in | input | 1 | Marks the last active pixel of the frame |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word taken |
| s_data | input | 64 | Stream word; pixel in bits 23:0 |
| s_eof | input | 1 | Stream end-of-frame marker |
| flag_clr | input | 2 | Write-1-to-clear strobes (bit0 underflow, bit1 overflow) |
| px_de | output | 1 | Registered data-enable |
| px_out | output | 24 | Registered pixel |
| flags | output | 2 | Sticky flags (bit0 underflow, bit1 overflow) |
| ss_bypass | output | 1 | Registered subsampler bypass |

## Verification
The assertions check on every cycle that data-enable is aligned and the blank output is zero. They also cover the idle handshake in disabled mode, constant-colour output, the coupling of ready to data-enable, underflow setting, clear-and-hold behaviour of the flags, and bypass forwarding. The bench scenarios are what show the ramp sequence restarting at each frame and the two overflow cases, since both overflow cases depend on where the raster is in the frame. The bench also shows set-beats-clear collisions under random stimulus.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_LIVE  = 2'd1,
        SRC_RAMP  = 2'd2,
        SRC_CONST = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        FR_WAIT   = 2'd0,
        FR_ACTIVE = 2'd1,
        FR_BLANK  = 2'd2
    } frame_st_e;

    localparam int FLAG_UNF  = 0;
    localparam int FLAG_OVF  = 1;
    localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/vsm_frame_fsm.sv
module vsm_frame_fsm
    import vsm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sof,
    input  logic      de,
    input  logic      last,
    output frame_st_e state,
    output logic      in_blank
);

    frame_st_e state_q;
    frame_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_WAIT: begin
                if (sof) begin
                    state_d = (de && last) ? FR_BLANK : FR_ACTIVE;
                end
            end
            FR_ACTIVE: begin
                if (de && last) begin
                    state_d = FR_BLANK;
                end else begin
                    state_d = FR_ACTIVE;
                end
            end
            FR_BLANK: begin
                if (sof) begin
                    state_d = (de && last) ? FR_BLANK : FR_ACTIVE;
                end
            end
            default: state_d = FR_WAIT;
        endcase
    end

    assign state    = state_q;
    assign in_blank = (state_q == FR_BLANK);

endmodule

// File: rtl/vsm_ramp_gen.sv
module vsm_ramp_gen #(
    parameter int PX_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof,
    input  logic            de,
    output logic [PX_W-1:0] ramp_val
);

    localparam logic [PX_W-1:0] ONE = PX_W'(1);

    logic [PX_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sof) begin
            cnt_q <= de ? ONE : '0;
        end else if (de) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign ramp_val = sof ? '0 : cnt_q;

endmodule

// File: rtl/vsm_sticky_flags.sv
module vsm_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else begin
                flags[i] <= set[i] | (flags[i] & ~clr[i]);
            end
        end
    end

endmodule

// File: rtl/vid_src_sel.sv
module vid_src_sel
    import vsm_pkg::*;
#(
    parameter int PX_W   = 24,
    parameter int STRM_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic [PX_W-1:0]   const_px,
    input  logic              bypass_req,
    input  logic              de_in,
    input  logic              sof_in,
    input  logic              last_in,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [STRM_W-1:0] s_data,
    input  logic              s_eof,
    input  logic [1:0]        flag_clr,
    output logic              px_de,
    output logic [PX_W-1:0]   px_out,
    output logic [1:0]        flags,
    output logic              ss_bypass
);

    src_sel_e        sel_e;
    frame_st_e       fr_state;
    logic            fr_blank;
    logic [PX_W-1:0] ramp_val;
    logic [PX_W-1:0] px_d;
    logic            is_live;
    logic            unf_set;
    logic            ovf_early;
    logic            ovf_blank;
    logic [NUM_FLAGS-1:0] flag_set;
    logic            unused_strm;
    frame_st_e       unused_state;

    assign sel_e        = src_sel_e'(src_sel);
    assign unused_strm  = ^s_data[STRM_W-1:PX_W];
    assign unused_state = fr_state;

    vsm_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (sof_in),
        .de       (de_in),
        .last     (last_in),
        .state    (fr_state),
        .in_blank (fr_blank)
    );

    vsm_ramp_gen #(.PX_W(PX_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (sof_in),
        .de       (de_in),
        .ramp_val (ramp_val)
    );

    // handshake and error detection
    assign is_live   = (sel_e == SRC_LIVE);
    assign s_ready   = is_live && de_in;
    assign unf_set   = is_live && de_in && !s_valid;
    assign ovf_early = s_valid && s_ready && s_eof && !last_in;
    assign ovf_blank = is_live && fr_blank && !sof_in && s_valid;

    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_UNF] = unf_set;
        flag_set[FLAG_OVF] = ovf_early || ovf_blank;
    end

    vsm_sticky_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flags)
    );

    // pixel source choice
    always_comb begin
        px_d = '0;
        if (de_in) begin
            unique case (sel_e)
                SRC_OFF:   px_d = '0;
                SRC_LIVE:  px_d = s_valid ? s_data[PX_W-1:0] : '0;
                SRC_RAMP:  px_d = ramp_val;
                SRC_CONST: px_d = const_px;
                default:   px_d = '0;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_de     <= 1'b0;
            px_out    <= '0;
            ss_bypass <= 1'b0;
        end else begin
            px_de     <= de_in;
            px_out    <= px_d;
            ss_bypass <= bypass_req;
        end
    end

endmodule

// File: rtl/vid_src_sel_chk.sv
module vid_src_sel_chk #(
    parameter int PX_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      src_sel,
    input logic [PX_W-1:0] const_px,
    input logic            bypass_req,
    input logic            de_in,
    input logic            s_valid,
    input logic            s_ready,
    input logic [1:0]      flag_clr,
    input logic            px_de,
    input logic [PX_W-1:0] px_out,
    input logic [1:0]      flags,
    input logic            ss_bypass
);

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (!px_de && px_out == '0 && flags == 2'b00 && !ss_bypass); // R1
        end
    end

    AST_DE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) de_in |=> px_de); // R2
    AST_DE_DROP: assert property (@(posedge clk) disable iff (!rst_n) !de_in |=> !px_de); // R2
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !px_de |-> px_out == '0); // R2
    AST_OFF_READY: assert property (@(posedge clk) disable iff (!rst_n) src_sel == 2'd0 |-> !s_ready); // R3
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) src_sel == 2'd0 |=> px_out == '0); // R3
    AST_CONST_PIX: assert property (@(posedge clk) disable iff (!rst_n) (src_sel == 2'd3 && de_in) |=> px_out == $past(const_px)); // R4
    AST_READY_DE: assert property (@(posedge clk) disable iff (!rst_n) s_ready |-> de_in); // R6
    AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n) (src_sel == 2'd1 && de_in && !s_valid) |=> flags[0]); // R7
    AST_UNF_CLR: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr[0] && src_sel != 2'd1) |=> !flags[0]); // R10
    AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (flags[0] && !flag_clr[0]) |=> flags[0]); // R10
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (flags[1] && !flag_clr[1]) |=> flags[1]); // R10
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n) bypass_req |=> ss_bypass); // R11

endmodule

bind vid_src_sel vid_src_sel_chk #(.PX_W(PX_W)) u_chk (.*);

// File: tb/vid_src_sel_tb.sv
module vid_src_sel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = '0;
    logic [23:0] const_px = '0;
    logic        bypass_req = 1'b0;
    logic        de_in = 1'b0;
    logic        sof_in = 1'b0;
    logic        last_in = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [63:0] s_data = '0;
    logic        s_eof = 1'b0;
    logic [1:0]  flag_clr = '0;
    logic        px_de;
    logic [23:0] px_out;
    logic [1:0]  flags;
    logic        ss_bypass;

    int n_vec = 0;
    int n_bad = 0;
    int n_cyc = 0;

    // bench model state: 0 wait, 1 active, 2 blank
    int          m_st = 0;
    logic [23:0] m_cnt = '0;
    logic [1:0]  m_flags = '0;

    // random stream knobs
    int p_valid_de = 8;
    int p_valid_bl = 8;
    int p_clr      = 8;
    int p_early    = 20;

    vid_src_sel u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .const_px   (const_px),
        .bypass_req (bypass_req),
        .de_in      (de_in),
        .sof_in     (sof_in),
        .last_in    (last_in),
        .s_valid    (s_valid),
        .s_ready    (s_ready),
        .s_data     (s_data),
        .s_eof      (s_eof),
        .flag_clr   (flag_clr),
        .px_de      (px_de),
        .px_out     (px_out),
        .flags      (flags),
        .ss_bypass  (ss_bypass)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        n_cyc <= n_cyc + 1;
        if (n_cyc > WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", n_cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_pixel(input logic [1:0] sel, input logic de,
                                              input logic sof, input logic [23:0] cnt,
                                              input logic vld, input logic [63:0] dat,
                                              input logic [23:0] cpx);
        if (!de) return '0;
        case (sel)
            2'd1:    return vld ? dat[23:0] : 24'd0;
            2'd2:    return sof ? 24'd0 : cnt;
            2'd3:    return cpx;
            default: return '0;
        endcase
    endfunction

    function automatic string px_tag(input logic [1:0] sel, input logic de, input logic vld);
        if (!de) return "R2 blank pixel";
        case (sel)
            2'd0:    return "R3 disabled pixel";
            2'd1:    return vld ? "R6 live pixel" : "R7 underflow pixel";
            2'd2:    return "R5 ramp pixel";
            default: return "R4 constant pixel";
        endcase
    endfunction

    // one clock: inputs already driven just after a negedge
    task automatic cyc();
        logic [23:0] e_px;
        logic        e_rdy;
        logic        unf;
        logic        ovf;
        logic [1:0]  nf;
        int          n_st;
        logic [23:0] n_cnt;
        logic        e_byp;
        string       tg;
        e_px  = exp_pixel(src_sel, de_in, sof_in, m_cnt, s_valid, s_data, const_px);
        tg    = px_tag(src_sel, de_in, s_valid);
        e_rdy = (src_sel == 2'd1) && de_in;
        e_byp = bypass_req;
        unf   = (src_sel == 2'd1) && de_in && !s_valid;
        ovf   = (src_sel == 2'd1) &&
                ((de_in && s_valid && s_eof && !last_in) || (m_st == 2 && !sof_in && s_valid));
        nf    = (m_flags & ~flag_clr) | {ovf, unf};
        if (sof_in)                              n_st = (de_in && last_in) ? 2 : 1;
        else if (m_st == 1 && de_in && last_in)  n_st = 2;
        else                                     n_st = m_st;
        if (sof_in)     n_cnt = de_in ? 24'd1 : 24'd0;
        else if (de_in) n_cnt = m_cnt + 24'd1;
        else            n_cnt = m_cnt;
        #1;
        chk("R6 ready", {31'd0, s_ready}, {31'd0, e_rdy});
        @(negedge clk);
        chk("R2 data-enable", {31'd0, px_de}, {31'd0, de_in});
        chk(tg, {8'd0, px_out}, {8'd0, e_px});
        chk(ovf ? "R8/R9 overflow flag" : "R10 flag", {30'd0, flags}, {30'd0, nf});
        chk("R11 bypass", {31'd0, ss_bypass}, {31'd0, e_byp});
        m_st    = n_st;
        m_cnt   = n_cnt;
        m_flags = nf;
    endtask

    task automatic drive_stream(input logic de, input logic last);
        s_valid = de ? (($urandom % p_valid_de) != 0) : (($urandom % p_valid_bl) == 0);
        s_data  = {$urandom, $urandom};
        s_eof   = s_valid && (last ? 1'b1 : (($urandom % p_early) == 0));
        flag_clr[0] = (($urandom % p_clr) == 0);
        flag_clr[1] = (($urandom % p_clr) == 0);
        bypass_req  = $urandom[0];
    endtask

    task automatic run_frame(input logic [1:0] sel, input int w, input int h, input int hb);
        src_sel  = sel;
        const_px = $urandom;
        for (int ln = 0; ln < h; ln++) begin
            for (int px = 0; px < w + hb; px++) begin
                de_in   = (px < w);
                sof_in  = (ln == 0 && px == 0);
                last_in = (ln == h - 1 && px == w - 1);
                drive_stream(de_in, last_in);
                cyc();
            end
        end
        de_in = 0; sof_in = 0; last_in = 0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            de_in = 0; sof_in = 0; last_in = 0;
            drive_stream(1'b0, 1'b0);
            cyc();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset px_de", {31'd0, px_de}, 32'd0);
        chk("R1 reset px_out", {8'd0, px_out}, 32'd0);
        chk("R1 reset flags", {30'd0, flags}, 32'd0);
        chk("R1 reset bypass", {31'd0, ss_bypass}, 32'd0);
        rst_n = 1'b1;

        // directed, clean stream: no valid in blank, no early eof, no clears
        p_valid_de = 1 << 30; p_valid_bl = 1 << 30; p_clr = 1 << 30; p_early = 1 << 30;
        idle_cycles(2);
        run_frame(2'd0, 4, 2, 2);   // R3
        run_frame(2'd3, 4, 2, 2);   // R4
        run_frame(2'd2, 5, 3, 1);   // R5 ramp restart
        run_frame(2'd2, 3, 2, 2);   // R5 second frame restarts at 0
        run_frame(2'd1, 4, 2, 2);   // R6 clean live frame, flags stay clear
        chk("R6 clean live leaves flags", {30'd0, flags}, 32'd0);

        // R7: one missing word
        src_sel = 2'd1; de_in = 1; sof_in = 1; last_in = 0;
        s_valid = 0; s_eof = 0; flag_clr = 0; cyc();
        chk("R7 underflow sticky", {31'd0, flags[0]}, 32'd1);
        // R8: early eof on non-last pixel
        sof_in = 0; s_valid = 1; s_eof = 1; s_data = 64'h0123_4567_89ab_cdef; cyc();
        chk("R8 early eof overflow", {31'd0, flags[1]}, 32'd1);
        // R10: clear both, set wins on underflow in same cycle
        s_valid = 0; s_eof = 0; flag_clr = 2'b11; cyc();
        chk("R10 set beats clear", {30'd0, flags}, 32'd1);
        de_in = 0; flag_clr = 2'b01; cyc();
        chk("R10 clear underflow", {30'd0, flags}, 32'd0);
        // R9: reach blank then present data
        flag_clr = 0; de_in = 1; last_in = 1; s_valid = 1; s_eof = 1; cyc();
        chk("R9 last pixel no overflow", {30'd0, flags}, 32'd0);
        de_in = 0; last_in = 0; s_valid = 1; s_eof = 0; cyc();
        chk("R9 valid in blank overflow", {31'd0, flags[1]}, 32'd1);
        s_valid = 0; flag_clr = 2'b11; cyc();
        flag_clr = 0;

        // random frames
        p_valid_de = 8; p_valid_bl = 6; p_clr = 10; p_early = 24;
        for (int f = 0; f < 300; f++) begin
            run_frame(2'($urandom), 2 + ($urandom % 6), 1 + ($urandom % 3), 1 + ($urandom % 3));
            idle_cycles($urandom % 3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule